// File: doc/BRIEF.md
# Hot-Plug Slot Event Controller

This block holds the slot control and slot status state of a hot-plug capable downstream or root port. Software reaches it through a 32-bit configuration write port with per-byte enables and a read port. It keeps the three event status flags, the event enables, the attention and power indicator fields, the power-controller-off bit, presence detect and the electromechanical interlock state. Physical slot activity (a hot-add completing, an unplug request from the attention button) enters as single-cycle strobes.

From the event flags and enables the block derives one notify condition. It reports a change of that condition either as a one-cycle message request tagged with the interrupt message number, when message signalled interrupts are enabled, or as a level on a legacy interrupt line. Every command written to the control half completes in the cycle it is accepted. A specific power-off command detaches the present device.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the read word is {status[15:0], control[15:0]}. Control holds event enables = 0 (bits 2:0), notify enable = 0 (bit 3), attention indicator = off (bits 5:4 = 2'b11) and interlock command bit 9 = 0. Status holds event flags = 0 (bits 2:0: bit 0 attention button, bit 1 presence changed, bit 2 command completed) and interlock state = 0 (bit 4). Presence (bit 3) equals the strap input, and setting it this way raises no event.
- R2: With a power controller fitted, reset of an empty slot gives power-off (control bit 8) = 1 and power indicator (bits 7:6) = off (2'b11). Reset of a populated slot gives power-off = 0 and power indicator = on (2'b01).
- R3: The notify condition is true when control bit 3 is set and any status event bit 2:0 is set together with its enable at the same position. When MSI or MSI-X is enabled, msg_req pulses for one cycle, the cycle after the condition changes value in either direction. Raising an event flag that is already set gives no pulse.
- R4: When neither MSI nor MSI-X is enabled, intx equals the registered notify condition. Otherwise intx is 0.
- R5: msg_vec carries the int_msg_num value present in the cycle in which the change was taken.
- R6: Status event flags are write-one-to-clear through byte lane 2 (cfg_wdata bits 18:16). Presence and interlock state cannot be written. Lanes without an active enable have no effect.
- R7: Writing 1 to control bit 9 (lane 1) toggles the interlock state. Bit 9 always reads 0.
- R8: Control fields update only in enabled lanes: lane 0 holds bits 7:0 and lane 1 holds bit 8. Any write with lane 0 or lane 1 enabled sets the command-completed flag in the same update.
- R9: A write touching control while presence is set, with written bit 8 = 1 and written bits 7:6 = 2'b11, clears presence and sets the presence-changed flag.
- R10: A hot_add strobe sets presence, presence-changed and attention-button flags. An unplug_req strobe sets only the attention-button flag. Flags set in a cycle win over a clear written in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_present | input | 1 | Static presence strap sampled by reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables: lanes 1:0 control, lanes 3:2 status |
| cfg_wdata | input | 32 | Write data {status, control} |
| cfg_rdata | output | 32 | Read data {status, control} |
| hot_add | input | 1 | Hot-add completion strobe |
| unplug_req | input | 1 | Unplug request strobe |
| msi_en | input | 1 | MSI enabled |
| msix_en | input | 1 | MSI-X enabled |
| int_msg_num | input | 5 | Interrupt message number |
| msg_req | output | 1 | One-cycle message request |
| msg_vec | output | 5 | Vector carried by the message request |
| intx | output | 1 | Legacy level interrupt |

## Verification
A corrupted event flag or enable becomes visible on cfg_rdata in the cycle after the update that caused it. Through the notify condition it also shows as a wrong msg_req pulse or intx level in that same cycle. A wrong held condition bit produces a missing or extra pulse at the next change, so the bench compares every output after every update against a model driven only by the requirements. A lost interlock toggle or a missed detach stays visible in the read word until another command changes it.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int EVT_N   = 3;
  localparam int EV_AB   = 0;
  localparam int EV_PDC  = 1;
  localparam int EV_CC   = 2;
  localparam logic [EVT_N-1:0] EV_SUPPORTED = 3'b111;

  localparam logic [1:0] IND_RSVD = 2'b00;
  localparam logic [1:0] IND_ON   = 2'b01;
  localparam logic [1:0] IND_OFF  = 2'b11;

  typedef struct packed {
    logic             pwr_off;
    logic [1:0]       pwr_ind;
    logic [1:0]       attn_ind;
    logic             hp_ie;
    logic [EVT_N-1:0] ev_en;
  } slot_ctl_t;

  typedef struct packed {
    logic             lock;
    logic             present;
    logic [EVT_N-1:0] ev;
  } slot_sts_t;

  function automatic logic [15:0] ctl_word(slot_ctl_t c);
    return {6'd0, 1'b0, c.pwr_off, c.pwr_ind, c.attn_ind, c.hp_ie, c.ev_en};
  endfunction

  function automatic logic [15:0] sts_word(slot_sts_t s);
    return {11'd0, s.lock, s.present, s.ev};
  endfunction
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_present,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             hot_add,
  input  logic             unplug_req,
  output slot_ctl_t        ctl_q,
  output slot_sts_t        sts_q,
  output logic             ie_nx,
  output logic [EVT_N-1:0] en_nx,
  output logic [EVT_N-1:0] ev_nx
);
  slot_ctl_t  ctl_n, ctl_rst;
  slot_sts_t  sts_n;
  logic       ctl_touch, detach, upd;
  logic [1:0] rst_pwr_ind;
  logic       rst_pwr_off;
  logic       unused_wdata;

  assign unused_wdata = ^{wr_data[31:19], wr_data[15:10]};

  generate
    if (HAS_PWR_CTRL) begin : g_pwr_ctrl
      assign rst_pwr_ind = strap_present ? IND_ON : IND_OFF;
      assign rst_pwr_off = ~strap_present;
    end else begin : g_no_pwr_ctrl
      assign rst_pwr_ind = IND_RSVD;
      assign rst_pwr_off = 1'b0;
    end
  endgenerate

  always_comb begin
    ctl_rst          = '0;
    ctl_rst.attn_ind = IND_OFF;
    ctl_rst.pwr_ind  = rst_pwr_ind;
    ctl_rst.pwr_off  = rst_pwr_off;
  end

  assign ctl_touch = wr_en & (|wr_be[1:0]);
  assign detach    = ctl_touch & sts_q.present & wr_data[8] & (wr_data[7:6] == IND_OFF);
  assign upd       = wr_en | hot_add | unplug_req;

  always_comb begin
    ctl_n = ctl_q;
    sts_n = sts_q;
    if (wr_en && wr_be[0]) begin
      ctl_n.ev_en    = wr_data[2:0];
      ctl_n.hp_ie    = wr_data[3];
      ctl_n.attn_ind = wr_data[5:4];
      ctl_n.pwr_ind  = wr_data[7:6];
    end
    if (wr_en && wr_be[1]) begin
      ctl_n.pwr_off = HAS_PWR_CTRL ? wr_data[8] : 1'b0;
      if (wr_data[9]) sts_n.lock = ~sts_q.lock;
    end
    if (wr_en && wr_be[2]) sts_n.ev = sts_q.ev & ~wr_data[18:16];
    if (detach) begin
      sts_n.present    = 1'b0;
      sts_n.ev[EV_PDC] = 1'b1;
    end
    if (ctl_touch) sts_n.ev[EV_CC] = 1'b1;
    if (hot_add) begin
      sts_n.present    = 1'b1;
      sts_n.ev[EV_PDC] = 1'b1;
      sts_n.ev[EV_AB]  = 1'b1;
    end
    if (unplug_req) sts_n.ev[EV_AB] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q         <= ctl_rst;
      sts_q.ev      <= '0;
      sts_q.lock    <= 1'b0;
      sts_q.present <= strap_present;
    end else if (upd) begin
      ctl_q <= ctl_n;
      sts_q <= sts_n;
    end
  end

  assign ie_nx = ctl_n.hp_ie;
  assign en_nx = ctl_n.ev_en;
  assign ev_nx = sts_n.ev;

  // R7: a toggle command flips the interlock state
  a_r7_lock_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[9]) |=> (sts_q.lock != $past(sts_q.lock)));
  // R8: any control command completes at once
  a_r8_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_touch |=> sts_q.ev[EV_CC]);
  // R10: hot-add raises presence and both events
  a_r10_hot_add: assert property (@(posedge clk) disable iff (!rst_n)
    hot_add |=> (sts_q.present && sts_q.ev[EV_PDC] && sts_q.ev[EV_AB]));
  // R6: write-one-to-clear of the button flag with no competing set
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[2] && wr_data[16] && !hot_add && !unplug_req) |=> !sts_q.ev[EV_AB]);
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ie_nx,
  input  logic [EVT_N-1:0] en_nx,
  input  logic [EVT_N-1:0] ev_nx,
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [VEC_W-1:0] vec,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec,
  output logic             intx
);
  logic             cond_n, notify_q, msg_mode, change;
  logic             msg_q;
  logic [VEC_W-1:0] vec_q;

  assign cond_n   = ie_nx & (|(ev_nx & en_nx & EV_SUPPORTED));
  assign msg_mode = msi_en | msix_en;
  assign change   = cond_n ^ notify_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_q <= 1'b0;
      msg_q    <= 1'b0;
      vec_q    <= '0;
    end else begin
      notify_q <= cond_n;
      msg_q    <= msg_mode & change;
      if (msg_mode && change) vec_q <= vec;
    end
  end

  assign msg_req = msg_q;
  assign msg_vec = vec_q;
  assign intx    = ~msg_mode & notify_q;

  // R3: a message goes out only when the held condition changed
  a_r3_msg_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (notify_q != $past(notify_q)));
  // R5: the message carries the vector seen at the change
  a_r5_vec: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (msg_vec == $past(vec)));
  // R4: the level line is silent in message mode
  a_r4_intx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    intx |-> !(msi_en || msix_en));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W        = 5,
  parameter bit HAS_PWR_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_present,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             hot_add,
  input  logic             unplug_req,
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [VEC_W-1:0] int_msg_num,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec,
  output logic             intx
);
  slot_ctl_t        ctl_q;
  slot_sts_t        sts_q;
  logic             ie_nx;
  logic [EVT_N-1:0] en_nx, ev_nx;

  hp_slot_regs #(.HAS_PWR_CTRL(HAS_PWR_CTRL)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_present(strap_present),
    .wr_en(cfg_wr), .wr_be(cfg_be), .wr_data(cfg_wdata),
    .hot_add(hot_add), .unplug_req(unplug_req),
    .ctl_q(ctl_q), .sts_q(sts_q),
    .ie_nx(ie_nx), .en_nx(en_nx), .ev_nx(ev_nx)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
    .clk(clk), .rst_n(rst_n),
    .ie_nx(ie_nx), .en_nx(en_nx), .ev_nx(ev_nx),
    .msi_en(msi_en), .msix_en(msix_en), .vec(int_msg_num),
    .msg_req(msg_req), .msg_vec(msg_vec), .intx(intx)
  );

  assign cfg_rdata = {sts_word(sts_q), ctl_word(ctl_q)};
endmodule

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, strap_present, cfg_wr, hot_add, unplug_req, msi_en, msix_en;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [4:0]  int_msg_num, msg_vec;
  logic        msg_req, intx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [2:0] m_ev, m_en;
  logic [1:0] m_attn, m_pind;
  logic       m_ie, m_poff, m_pres, m_lock, m_cond, m_msg;
  logic [4:0] m_vec;

  always #2.5 clk = ~clk;

  hp_slot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_present(strap_present),
    .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hot_add(hot_add), .unplug_req(unplug_req), .msi_en(msi_en), .msix_en(msix_en),
    .int_msg_num(int_msg_num), .msg_req(msg_req), .msg_vec(msg_vec), .intx(intx)
  );

  function automatic logic [15:0] exp_ctl();
    return {6'd0, 1'b0, m_poff, m_pind, m_attn, m_ie, m_en};
  endfunction

  function automatic logic [15:0] exp_sts();
    return {11'd0, m_lock, m_pres, m_ev};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset(input logic strap);
    m_ev = '0; m_en = '0; m_ie = 1'b0; m_attn = 2'b11;
    m_pind = strap ? 2'b01 : 2'b11; m_poff = ~strap;
    m_pres = strap; m_lock = 1'b0; m_cond = 1'b0; m_msg = 1'b0; m_vec = '0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; strap_present = strap;
    cfg_wr = 0; cfg_be = '0; cfg_wdata = '0; hot_add = 0; unplug_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset(strap);
    @(negedge clk);
    chk("R1 control after reset", {16'd0, cfg_rdata[15:0]}, {16'd0, exp_ctl()});
    chk("R1 status after reset", {16'd0, cfg_rdata[31:16]}, {16'd0, exp_sts()});
    chk("R2 power fields after reset", {29'd0, cfg_rdata[8:6]},
        {29'd0, strap ? 3'b001 : 3'b111});
    chk("R3 no message after reset", {31'd0, msg_req}, 32'd0);
  endtask

  task automatic model_step(input logic wr, input logic [3:0] be, input logic [31:0] wd,
                            input logic ha, input logic ur);
    logic old_cond, old_pres, touch;
    old_cond = m_cond; old_pres = m_pres;
    touch = wr && (|be[1:0]);
    if (wr && be[0]) begin
      m_en = wd[2:0]; m_ie = wd[3]; m_attn = wd[5:4]; m_pind = wd[7:6];
    end
    if (wr && be[1]) begin
      m_poff = wd[8];
      if (wd[9]) m_lock = ~m_lock;
    end
    if (wr && be[2]) m_ev = m_ev & ~wd[18:16];
    if (touch && old_pres && wd[8] && wd[7:6] == 2'b11) begin
      m_pres = 1'b0; m_ev[1] = 1'b1;
    end
    if (touch) m_ev[2] = 1'b1;
    if (ha) begin m_pres = 1'b1; m_ev[1] = 1'b1; m_ev[0] = 1'b1; end
    if (ur) m_ev[0] = 1'b1;
    m_cond = m_ie && (|(m_ev & m_en));
    m_msg  = (msi_en || msix_en) && (m_cond != old_cond);
    if (m_msg) m_vec = int_msg_num;
  endtask

  task automatic step(input logic wr, input logic [3:0] be, input logic [31:0] wd,
                      input logic ha, input logic ur);
    cfg_wr = wr; cfg_be = be; cfg_wdata = wd; hot_add = ha; unplug_req = ur;
    model_step(wr, be, wd, ha, ur);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0; cfg_be = '0; cfg_wdata = '0; hot_add = 0; unplug_req = 0;
    chk("R8 control word", {16'd0, cfg_rdata[15:0]}, {16'd0, exp_ctl()});
    chk("R6 status word", {16'd0, cfg_rdata[31:16]}, {16'd0, exp_sts()});
    chk("R3 message pulse", {31'd0, msg_req}, {31'd0, m_msg});
    if (m_msg) chk("R5 message vector", {27'd0, msg_vec}, {27'd0, m_vec});
    chk("R4 level interrupt", {31'd0, intx},
        {31'd0, m_cond && !(msi_en || msix_en)});
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    msi_en = 1'b1; msix_en = 1'b0; int_msg_num = 5'd9;
    rst_n = 1'b1; strap_present = 1'b0;
    cfg_wr = 0; cfg_be = '0; cfg_wdata = '0; hot_add = 0; unplug_req = 0;

    do_reset(1'b0);
    // R10: hot-add sets presence and two events
    step(0, 4'b0000, 32'd0, 1, 0);
    chk("R10 presence after hot-add", {31'd0, cfg_rdata[19]}, 32'd1);
    // R3: enabling all events raises the condition, one message
    step(1, 4'b0001, 32'h0000_000F, 0, 0);
    chk("R3 pulse on rising condition", {31'd0, msg_req}, 32'd1);
    // R3: re-raising the attention flag gives no message
    step(0, 4'b0000, 32'd0, 0, 1);
    chk("R3 no pulse on re-raise", {31'd0, msg_req}, 32'd0);
    // R7: interlock toggle, command bit reads zero
    step(1, 4'b0010, 32'h0000_0200, 0, 0);
    chk("R7 interlock state set", {31'd0, cfg_rdata[20]}, 32'd1);
    chk("R7 command bit reads zero", {31'd0, cfg_rdata[9]}, 32'd0);
    step(1, 4'b0010, 32'h0000_0200, 0, 0);
    chk("R7 interlock state cleared", {31'd0, cfg_rdata[20]}, 32'd0);
    // R9: power-off with indicator off detaches
    step(1, 4'b0011, 32'h0000_01CF, 0, 0);
    chk("R9 presence cleared", {31'd0, cfg_rdata[19]}, 32'd0);
    // R6: clear every event, condition falls, one message
    step(1, 4'b0100, 32'h0007_0000, 0, 0);
    chk("R6 events cleared", {29'd0, cfg_rdata[18:16]}, 32'd0);
    // R6: status lane disabled, nothing cleared
    step(0, 4'b0000, 32'd0, 0, 1);
    step(1, 4'b1000, 32'h0007_0000, 0, 0);
    chk("R6 disabled lane ignored", {31'd0, cfg_rdata[16]}, 32'd1);
    // R4: level mode
    msi_en = 1'b0; int_msg_num = 5'd21;
    step(0, 4'b0000, 32'd0, 1, 0);
    chk("R4 level raised", {31'd0, intx}, 32'd1);
    step(1, 4'b0100, 32'h0007_0000, 0, 0);
    chk("R4 level dropped after clear", {31'd0, intx}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic       wr, ha, ur;
      logic [3:0] be;
      logic [31:0] wd;
      if (($urandom % 20) == 0) msi_en = ~msi_en;
      if (($urandom % 25) == 0) msix_en = ~msix_en;
      int_msg_num = 5'($urandom);
      wr = (($urandom % 2) == 0);
      be = 4'($urandom);
      wd = $urandom;
      ha = (($urandom % 30) == 0);
      ur = (($urandom % 30) == 0);
      step(wr, be, wd, ha, ur);
    end

    do_reset(1'b1);
    chk("R2 populated slot power on", {30'd0, cfg_rdata[7:6]}, 32'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule